// File: doc/BRIEF.md
# Video Stream Capture with Resolution Learning

This block sits on a parallel RGB video bus and stores every active pixel into an external frame memory, one 32-bit word per pixel. It has no configuration. It finds the line width by counting valid pixels inside each data-enable burst. It finds the frame height by counting the line ends seen before the first vertical sync. Pixels marked invalid, as when an upstream source runs dry, are skipped. They are not written and they do not add to the line width.

Nothing is written before the first frame boundary, because the height is unknown until then. From that boundary on, each frame is placed from word address zero. Each line starts at its line index times the learned width, which is a byte stride of four times the width. After every line end a one-cycle strobe tells a downstream consumer that a row of the memory is ready to refresh. The end of a line is taken from the falling data enable, so no horizontal sync input is needed.

Top module: `vidcap_top`

## Requirements
- R1: While reset is held at a rising clock edge, all of these are zero after that edge: width, height, frame count, line-done, write enable, write address and write data.
- R2: A frame boundary occurs when vsync is sampled high and at least one line end has been counted since the last boundary. At a boundary the frame count increments by one and the next pixel write goes to word address 0. Vsync with no counted lines has no effect.
- R3: At the first frame boundary the count of lines seen so far is latched as the height, and capture begins. No write occurs before that boundary, and later boundaries leave the height unchanged.
- R4: With capture on, each cycle with data enable and valid both high produces one write, visible one cycle after the sampling edge. The word holds red in bits 7:0, green in bits 15:8, blue in bits 23:16 and zero in bits 31:24. Successive pixels within a line use consecutive word addresses.
- R5: A cycle with data enable high and valid low writes nothing and does not advance the horizontal position. The learned width counts only valid pixels.
- R6: When data enable is sampled low while the horizontal position is nonzero, the position is stored as the width. This is repeated at every line end.
- R7: After a line end, the next write address is the new line index times the learned width. The line index counts line ends since the last frame boundary.
- R8: Line-done is high for exactly the one cycle after a line end, and only once capture is on.
- R9: The horizontal position and the line index are 12 bits wide and stop at 4095 instead of wrapping.
- R10: Vsync held high for several cycles produces only one frame-count increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| vsync_i | input | 1 | Vertical sync |
| de_i | input | 1 | Data enable, high during active pixels |
| valid_i | input | 1 | Pixel valid, low on underflowed pixels |
| red_i | input | 8 | Red component |
| green_i | input | 8 | Green component |
| blue_i | input | 8 | Blue component |
| width_o | output | 12 | Learned line width in pixels |
| height_o | output | 12 | Learned frame height in lines |
| frame_o | output | 16 | Frame boundary count |
| line_done_o | output | 1 | One-cycle strobe after each captured line |
| wr_addr_o | output | 24 | Word address of the write |
| wr_data_o | output | 32 | Packed pixel word |
| wr_en_o | output | 1 | Write enable |

## Verification
The stimulus scatters invalid pixels through the lines. A design that counted them would report too wide a line, write them to memory, and shift every later address. Vsync is held for several cycles and also raised before any line has been seen. A design that tested the level and not the line count would bump the frame count repeatedly, or take a boundary with no lines at all. A partial frame before the first vsync checks that nothing is written before the height is known. One very long line and a run of more than 4095 one-pixel lines check that a wrapping counter is caught: it would report a tiny width, or send the next row back near address zero.

// File: rtl/vidcap_pkg.sv
package vidcap_pkg;
    parameter int CW = 12;          // horizontal and vertical counter width
    parameter int FW = 16;          // frame counter width
    parameter int PW = 8;           // bits per colour component
    parameter int DW = 32;          // memory word width
    localparam int AW = 2 * CW;     // word address width, covers width*height

    typedef struct packed {
        logic [PW-1:0] b;
        logic [PW-1:0] g;
        logic [PW-1:0] r;
    } rgb_t;

    function automatic logic [DW-1:0] pack_word(rgb_t p);
        return {{(DW - 3*PW){1'b0}}, p.b, p.g, p.r};
    endfunction

    function automatic logic [CW-1:0] sat_inc(logic [CW-1:0] v);
        return (&v) ? v : v + 1'b1;
    endfunction
endpackage

// File: rtl/vidcap_hcount.sv
module vidcap_hcount
    import vidcap_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          de_i,
    input  logic          valid_i,
    output logic [CW-1:0] hpos_o,
    output logic [CW-1:0] width_o,
    output logic          line_end_o
);
    logic [CW-1:0] hpos_q;
    logic [CW-1:0] width_q;

    assign line_end_o = !de_i && (hpos_q != '0);
    assign hpos_o     = hpos_q;
    assign width_o    = width_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hpos_q  <= '0;
            width_q <= '0;
        end else if (de_i) begin
            if (valid_i) hpos_q <= sat_inc(hpos_q);
        end else if (line_end_o) begin
            width_q <= hpos_q;
            hpos_q  <= '0;
        end
    end
endmodule

// File: rtl/vidcap_vcount.sv
module vidcap_vcount
    import vidcap_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          vsync_i,
    input  logic          line_end_i,
    input  logic          width_zero_i,
    output logic          frame_start_o,
    output logic          cap_o,
    output logic [CW-1:0] line_next_o,
    output logic [CW-1:0] height_o,
    output logic [FW-1:0] frame_o
);
    logic [CW-1:0] line_q;
    logic [CW-1:0] height_q;
    logic [FW-1:0] frame_q;
    logic          cap_q;
    logic [CW-1:0] line_mid;

    assign frame_start_o = vsync_i && (line_q != '0);
    assign cap_o         = cap_q || frame_start_o;
    assign height_o      = height_q;
    assign frame_o       = frame_q;

    always_comb begin
        line_mid    = frame_start_o ? '0 : line_q;
        line_next_o = line_mid;
        if (line_end_i)
            line_next_o = sat_inc(width_zero_i ? '0 : line_mid);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q   <= '0;
            height_q <= '0;
            frame_q  <= '0;
            cap_q    <= 1'b0;
        end else begin
            line_q <= line_next_o;
            if (frame_start_o) begin
                frame_q <= frame_q + 1'b1;
                if (height_q == '0) begin
                    height_q <= line_q;
                    cap_q    <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/vidcap_writer.sv
module vidcap_writer
    import vidcap_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          frame_start_i,
    input  logic          line_end_i,
    input  logic          cap_i,
    input  logic          pix_ok_i,
    input  rgb_t          pix_i,
    input  logic [CW-1:0] line_next_i,
    input  logic [CW-1:0] hpos_i,
    output logic [AW-1:0] wr_addr_o,
    output logic [DW-1:0] wr_data_o,
    output logic          wr_en_o,
    output logic          line_done_o
);
    logic [AW-1:0] ptr_q;
    logic [AW-1:0] ptr_mid;
    logic [AW-1:0] line_base;

    assign ptr_mid   = frame_start_i ? '0 : ptr_q;
    assign line_base = AW'(line_next_i) * AW'(hpos_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q       <= '0;
            wr_addr_o   <= '0;
            wr_data_o   <= '0;
            wr_en_o     <= 1'b0;
            line_done_o <= 1'b0;
        end else begin
            wr_en_o     <= 1'b0;
            line_done_o <= line_end_i && cap_i;
            if (pix_ok_i && cap_i) begin
                wr_en_o   <= 1'b1;
                wr_addr_o <= ptr_mid;
                wr_data_o <= pack_word(pix_i);
                ptr_q     <= ptr_mid + 1'b1;
            end else if (line_end_i) begin
                ptr_q <= line_base;
            end else begin
                ptr_q <= ptr_mid;
            end
        end
    end
endmodule

// File: rtl/vidcap_top.sv
module vidcap_top
    import vidcap_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          vsync_i,
    input  logic          de_i,
    input  logic          valid_i,
    input  logic [PW-1:0] red_i,
    input  logic [PW-1:0] green_i,
    input  logic [PW-1:0] blue_i,
    output logic [CW-1:0] width_o,
    output logic [CW-1:0] height_o,
    output logic [FW-1:0] frame_o,
    output logic          line_done_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [DW-1:0] wr_data_o,
    output logic          wr_en_o
);
    logic [CW-1:0] hpos;
    logic          line_end;
    logic          frame_start;
    logic          cap;
    logic [CW-1:0] line_next;
    rgb_t          pix;

    assign pix = '{b: blue_i, g: green_i, r: red_i};

    vidcap_hcount u_hcount (
        .clk        (clk),
        .rst        (rst),
        .de_i       (de_i),
        .valid_i    (valid_i),
        .hpos_o     (hpos),
        .width_o    (width_o),
        .line_end_o (line_end)
    );

    vidcap_vcount u_vcount (
        .clk           (clk),
        .rst           (rst),
        .vsync_i       (vsync_i),
        .line_end_i    (line_end),
        .width_zero_i  (width_o == '0),
        .frame_start_o (frame_start),
        .cap_o         (cap),
        .line_next_o   (line_next),
        .height_o      (height_o),
        .frame_o       (frame_o)
    );

    vidcap_writer u_writer (
        .clk           (clk),
        .rst           (rst),
        .frame_start_i (frame_start),
        .line_end_i    (line_end),
        .cap_i         (cap),
        .pix_ok_i      (de_i && valid_i),
        .pix_i         (pix),
        .line_next_i   (line_next),
        .hpos_i        (hpos),
        .wr_addr_o     (wr_addr_o),
        .wr_data_o     (wr_data_o),
        .wr_en_o       (wr_en_o),
        .line_done_o   (line_done_o)
    );
endmodule

// File: rtl/vidcap_checker.sv
module vidcap_checker
    import vidcap_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          vsync_i,
    input logic          de_i,
    input logic [CW-1:0] width_o,
    input logic [CW-1:0] height_o,
    input logic [FW-1:0] frame_o,
    input logic          line_done_o,
    input logic [AW-1:0] wr_addr_o,
    input logic          wr_en_o
);
    // R1: reset leaves the write port and frame count idle
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!wr_en_o && frame_o == '0 && height_o == '0));

    // R3: no write while the height is still unknown
    a_r3_no_early_write: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> (height_o != '0));

    // R4: back-to-back writes without a vsync sample step by one word
    a_r4_addr_step: assert property (@(posedge clk) disable iff (rst)
        (wr_en_o && $past(wr_en_o) && !$past(vsync_i))
        |-> (wr_addr_o == $past(wr_addr_o) + 1'b1));

    // R6: width only changes after data enable was sampled low
    a_r6_width_on_line_end: assert property (@(posedge clk) disable iff (rst)
        (width_o != $past(width_o)) |-> !$past(de_i));

    // R8: line-done never lasts two cycles
    a_r8_line_done_pulse: assert property (@(posedge clk) disable iff (rst)
        line_done_o |=> !line_done_o);

    // R10: frame count moves by one, only after vsync
    a_r10_frame_step: assert property (@(posedge clk) disable iff (rst)
        (frame_o != $past(frame_o))
        |-> (frame_o == FW'($past(frame_o) + 1'b1) && $past(vsync_i)));
endmodule

bind vidcap_top vidcap_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .vsync_i     (vsync_i),
    .de_i        (de_i),
    .width_o     (width_o),
    .height_o    (height_o),
    .frame_o     (frame_o),
    .line_done_o (line_done_o),
    .wr_addr_o   (wr_addr_o),
    .wr_en_o     (wr_en_o)
);

// File: tb/tb_vidcap_top.sv
module tb_vidcap_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        vsync = 1'b0, de = 1'b0, valid = 1'b0;
    logic [7:0]  red = '0, green = '0, blue = '0;
    logic [11:0] width, height;
    logic [15:0] frame;
    logic        line_done, wr_en;
    logic [23:0] wr_addr;
    logic [31:0] wr_data;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // reference state built from the requirements
    int m_x = 0, m_y = 0, m_w = 0, m_h = 0, m_f = 0, m_ptr = 0;
    bit m_cap = 0;
    bit e_wr = 0, e_ld = 0;
    int e_addr = 0;
    logic [31:0] e_data = '0;

    always #5 clk = ~clk;

    vidcap_top dut (
        .clk(clk), .rst(rst), .vsync_i(vsync), .de_i(de), .valid_i(valid),
        .red_i(red), .green_i(green), .blue_i(blue),
        .width_o(width), .height_o(height), .frame_o(frame),
        .line_done_o(line_done), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .wr_en_o(wr_en)
    );

    function automatic int sat12(int v);
        return (v >= 4095) ? 4095 : v + 1;
    endfunction

    function automatic logic [31:0] word_of(logic [7:0] r, logic [7:0] g, logic [7:0] b);
        return {8'h00, b, g, r};
    endfunction

    task automatic check(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        bit fs;
        int ym, pm, ny;
        fs = vsync && (m_y != 0);
        ym = m_y; pm = m_ptr;
        if (fs) begin
            if (m_h == 0) begin m_h = m_y; m_cap = 1; end
            m_f = (m_f + 1) & 16'hffff;
            ym = 0; pm = 0;
        end
        e_wr = 0; e_ld = 0;
        if (de) begin
            if (valid && m_cap) begin
                e_wr = 1; e_addr = pm; e_data = word_of(red, green, blue);
                pm = pm + 1;
            end
            if (valid) m_x = sat12(m_x);
        end else if (m_x != 0) begin
            e_ld = m_cap;
            ny   = sat12((m_w == 0) ? 0 : ym);
            m_w  = m_x;
            pm   = ny * m_x;
            m_x  = 0;
            ym   = ny;
        end
        m_y = ym; m_ptr = pm;
    endtask

    task automatic cyc(bit vs, bit d, bit v);
        @(negedge clk);
        vsync = vs; de = d; valid = v;
        red = 8'($urandom); green = 8'($urandom); blue = 8'($urandom);
        @(posedge clk);
        model_step();
        #1;
        check("R3/R5 write enable", wr_en, e_wr);
        if (e_wr) begin
            check("R7 write address", wr_addr, e_addr);
            check("R4 write data", wr_data, e_data);
        end
        check("R8 line done", line_done, e_ld);
        check("R6 width", width, m_w);
        check("R3 height", height, m_h);
        check("R2 frame count", frame, m_f);
    endtask

    task automatic line(int w, int blank, int bad_pct);
        int n = 0;
        while (n < w) begin
            if (($urandom % 100) < bad_pct) cyc(0, 1, 0);
            else begin cyc(0, 1, 1); n++; end
        end
        repeat (blank) cyc(0, 0, 0);
    endtask

    task automatic vblank(int hold);
        cyc(0, 0, 0);
        repeat (hold) cyc(1, 0, 0);
        cyc(0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1 width", width, 0);
        check("R1 height", height, 0);
        check("R1 frame", frame, 0);
        check("R1 wr_en", wr_en, 0);
        check("R1 line_done", line_done, 0);
        check("R1 wr_addr", wr_addr, 0);
        check("R1 wr_data", wr_data, 0);
        @(negedge clk); rst = 1'b0;

        // R2: vsync with no lines counted does nothing
        repeat (3) cyc(1, 0, 0);
        check("R2 idle vsync frame", frame, 0);

        // R3: partial frame before first boundary, no writes, underflow mixed in (R5)
        repeat (3) line(5, 3, 20);
        check("R5 width excludes invalid", width, 5);
        check("R3 no height yet", height, 0);
        vblank(3);
        check("R3 height latched", height, 3);
        check("R10 single increment", frame, 1);

        // random frames
        for (int f = 0; f < 6; f++) begin
            int w = 3 + ($urandom % 10);
            int h = 2 + ($urandom % 5);
            for (int l = 0; l < h; l++) line(w, 2 + ($urandom % 3), 25);
            check("R6 width per frame", width, w);
            vblank(1 + ($urandom % 3));
        end
        check("R3 height kept", height, 3);

        // R9: horizontal saturation
        line(4100, 2, 0);
        check("R9 width saturates", width, 4095);
        vblank(2);

        // R9: line index saturation, one pixel per line
        for (int l = 0; l < 4100; l++) line(1, 1, 0);
        cyc(0, 1, 1);
        check("R9 line index saturates", wr_addr, 4095);
        repeat (2) cyc(0, 0, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule